// File: doc/BRIEF.md
# Tag Memory Command Handler with Serial CRC-4

This block is the protocol layer of a simulated contactless memory tag. It sits between a frame receiver, which delivers whole reader frames with a bit count and an error flag, and a frame transmitter, which accepts reply requests. It owns a byte memory of up to 1024 entries. After a short three-frame handshake it serves read and write commands. The handshake receives a start frame, replies with a card-type code and then checks the reader's acknowledge.

The block never looks at an opcode. A command is classified only by how many bits it carries, and that count depends on the card kind latched during reset. A 4-bit checksum is formed one bit per clock over the data byte placed above the command field. Reads return the byte together with its checksum. A write is stored only when the checksum carried in the frame matches the computed one. Any protocol error drops the link, and the block then waits for a new start frame. The bit-level physical layers and the keystream are handled elsewhere.

A test-only preload port writes the memory directly.

Top module: `tagcmd_handler`

## Requirements
- R1: `card_type_i` is sampled while `rst_n` is low. Kind 0 has a 6-bit command and a 5-bit address. Kind 1 has a 9-bit command and an 8-bit address. Kind 2 has an 11-bit command and a 10-bit address. The matching memory sizes are 22, 256 and 1024 bytes. Kind 3 is unsupported: the block never replies and `link_o` stays 0.
- R2: While unlinked, an error-free 7-bit frame produces one reply with `tx_len_o`=6. Its `tx_bits_o[5:0]` carries the kind code: 0x0D, 0x1D or 0x3D for kinds 0, 1 and 2. Any other length, or a frame with `rx_err_i` set, gets no reply.
- R3: After the kind reply, an error-free 6-bit frame equal to 0x19 (kind 0) or 0x39 (kinds 1 and 2) raises `link_o`. In the same cycle, `ref_adv_o` pulses once to push the timing reference forward by one bit period. Any other frame returns the block to waiting for a 7-bit frame, with `link_o` still 0.
- R4: The checksum starts at 0x5. Payload bits are taken LSB first. For each bit d: fb = c[0]^d, c = c>>1, and if fb is set then c ^= 0xC. The payload is (byte << command width) | command, and it covers 8 + command width bits.
- R5: While linked, a frame whose length equals the command width is a read. The address is frame bits [cw-1:1]. The reply has `tx_len_o`=12. Bits [7:0] hold the stored byte and bits [11:8] hold the checksum over that byte and the full received command, including bit 0.
- R6: While linked, a frame of command width + 12 bits is a write. The address is bits [aw:1], the byte is bits [cw+7:cw] and the checksum is bits [cw+11:cw+8]. The checksum is recomputed with command bit 0 cleared. On a match the byte is stored, and an acknowledge is sent with `tx_len_o`=1, `tx_bits_o`=1 and `tx_ack_o`=1.
- R7: A write whose checksum does not match stores nothing, sends nothing and drops `link_o`.
- R8: While linked, a frame with `rx_err_i` set, or of any other length, sends nothing and drops `link_o`. The next frame is then treated as a start frame.
- R9: Each accepted frame produces at most one reply. `tx_valid_o` is a single-cycle pulse.
- R10: Reset clears `link_o`, `tx_valid_o` and `ref_adv_o`.
- R11: A byte written through the preload port is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; card kind is sampled while low |
| card_type_i | input | 2 | Card kind selector |
| rx_valid_i | input | 1 | One-cycle strobe: a received frame is present |
| rx_err_i | input | 1 | Received frame ended in a code violation |
| rx_len_i | input | 5 | Received frame bit count |
| rx_bits_i | input | 23 | Received frame bits, first bit in bit 0 |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | 10 | Preload address |
| pre_data_i | input | 8 | Preload data |
| tx_valid_o | output | 1 | One-cycle reply request |
| tx_ack_o | output | 1 | Reply is a write acknowledge (long wait slot) |
| tx_len_o | output | 4 | Reply bit count |
| tx_bits_o | output | 12 | Reply bits, first bit in bit 0 |
| ref_adv_o | output | 1 | Push the next-frame timing reference by one bit period |
| link_o | output | 1 | Handshake complete, commands served |

## Verification
The assertions watch, on every cycle, the shape of what leaves the block. A reply sent before linking is 6 bits. A data reply sent while linked is 12 bits. An acknowledge follows a memory store on the previous cycle. A store only happens while linked. The timing-reference pulse coincides with the rise of the link, and an unsupported kind stays silent. Only the bench scenarios can show that the reply values are right. These are the kind codes, the checksum over each byte and command, the bit-field positions in write frames, the refusal of bad acknowledges, lengths and checksums, and that a failed write leaves memory unchanged. The bench covers these by sweeping every address of each card kind.

// File: rtl/tagcmd_pkg.sv
package tagcmd_pkg;

  localparam int CMD_MAX  = 11;
  localparam int BYTE_W   = 8;
  localparam int CRC_W    = 4;
  localparam int PAY_W    = CMD_MAX + BYTE_W;
  localparam int TX_W     = CRC_W + BYTE_W;
  localparam int TXL_W    = $clog2(TX_W + 1);
  localparam int IV_LEN   = 7;
  localparam int HS_LEN   = 6;
  localparam int WR_EXTRA = BYTE_W + CRC_W;

  localparam logic [CRC_W-1:0] CRC_POLY = 4'hC;
  localparam logic [CRC_W-1:0] CRC_SEED = 4'h5;

  typedef enum logic [1:0] {
    KIND_22   = 2'd0,
    KIND_256  = 2'd1,
    KIND_1024 = 2'd2,
    KIND_NONE = 2'd3
  } card_kind_e;

  function automatic bit kind_ok(input card_kind_e k);
    return k != KIND_NONE;
  endfunction

  function automatic int kind_cmd_w(input card_kind_e k);
    case (k)
      KIND_22:   return 6;
      KIND_256:  return 9;
      KIND_1024: return 11;
      default:   return 0;
    endcase
  endfunction

  function automatic int kind_addr_w(input card_kind_e k);
    case (k)
      KIND_22:   return 5;
      KIND_256:  return 8;
      KIND_1024: return 10;
      default:   return 0;
    endcase
  endfunction

  function automatic logic [HS_LEN-1:0] kind_reply(input card_kind_e k);
    case (k)
      KIND_22:   return 6'h0D;
      KIND_256:  return 6'h1D;
      default:   return 6'h3D;
    endcase
  endfunction

  function automatic logic [HS_LEN-1:0] kind_ack(input card_kind_e k);
    return (k == KIND_22) ? 6'h19 : 6'h39;
  endfunction

  // one reflected checksum step, data bit enters at the low end
  function automatic logic [CRC_W-1:0] crc4_step(input logic [CRC_W-1:0] c,
                                                 input logic d);
    logic             fb;
    logic [CRC_W-1:0] n;
    fb = c[0] ^ d;
    n  = c >> 1;
    if (fb) n = n ^ CRC_POLY;
    return n;
  endfunction

  // byte placed above a command field of width cw
  function automatic logic [PAY_W-1:0] crc_payload(input logic [CMD_MAX-1:0] cmd,
                                                   input logic [BYTE_W-1:0]  b,
                                                   input int                 cw);
    return (PAY_W'(b) << cw) | PAY_W'(cmd);
  endfunction

endpackage

// File: rtl/tagcmd_crc4_serial.sv
module tagcmd_crc4_serial
  import tagcmd_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PAY_W-1:0] payload_i,
  input  logic [CNT_W-1:0] nbits_i,
  output logic             done_o,
  output logic [CRC_W-1:0] crc_o
);

  logic [PAY_W-1:0] sh_q;
  logic [CNT_W-1:0] left_q;
  logic             run_q;
  logic             done_q;
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      crc_q  <= CRC_SEED;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        sh_q   <= payload_i;
        left_q <= nbits_i;
        run_q  <= 1'b1;
        crc_q  <= CRC_SEED;
      end else if (run_q) begin
        crc_q  <= crc4_step(crc_q, sh_q[0]);
        sh_q   <= sh_q >> 1;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign crc_o  = crc_q;

endmodule

// File: rtl/tagcmd_decode.sv
module tagcmd_decode
  import tagcmd_pkg::*;
#(
  parameter int RX_W  = 23,
  parameter int LEN_W = 5,
  parameter int AW    = 10
) (
  input  card_kind_e          kind_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [RX_W-1:0]     bits_i,
  output logic                is_read_o,
  output logic                is_write_o,
  output logic [CMD_MAX-1:0]  cmd_o,
  output logic [AW-1:0]       addr_o,
  output logic [BYTE_W-1:0]   byte_o,
  output logic [CRC_W-1:0]    crc_o
);

  int              cw;
  int              aw;
  logic [RX_W-1:0] cmd_mask;
  logic [RX_W-1:0] addr_mask;

  always_comb begin
    cw         = kind_cmd_w(kind_i);
    aw         = kind_addr_w(kind_i);
    cmd_mask   = (RX_W'(1) << cw) - RX_W'(1);
    addr_mask  = (RX_W'(1) << aw) - RX_W'(1);
    is_read_o  = (cw != 0) && (int'(len_i) == cw);
    is_write_o = (cw != 0) && (int'(len_i) == cw + WR_EXTRA);
    cmd_o      = CMD_MAX'(bits_i & cmd_mask);
    addr_o     = AW'((bits_i >> 1) & addr_mask);
    byte_o     = BYTE_W'(bits_i >> cw);
    crc_o      = CRC_W'(bits_i >> (cw + BYTE_W));
  end

endmodule

// File: rtl/tagcmd_mem.sv
module tagcmd_mem
  import tagcmd_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[addr_i] <= wdata_i;
    rdata_o <= cells[addr_i];
  end

endmodule

// File: rtl/tagcmd_handler.sv
module tagcmd_handler
  import tagcmd_pkg::*;
#(
  parameter int  MEM_DEPTH = 1024,
  parameter int  RX_W      = 23,
  parameter int  LEN_W     = 5,
  localparam int AW        = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        card_type_i,
  input  logic              rx_valid_i,
  input  logic              rx_err_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic [RX_W-1:0]   rx_bits_i,
  input  logic              pre_we_i,
  input  logic [AW-1:0]     pre_addr_i,
  input  logic [BYTE_W-1:0] pre_data_i,
  output logic              tx_valid_o,
  output logic              tx_ack_o,
  output logic [TXL_W-1:0]  tx_len_o,
  output logic [TX_W-1:0]   tx_bits_o,
  output logic              ref_adv_o,
  output logic              link_o
);

  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT_IV, ST_WAIT_ACK, ST_LINKED,
    ST_RD_FETCH, ST_RD_LOAD, ST_RD_CRC, ST_WR_CRC
  } phase_e;

  phase_e            state_q;
  card_kind_e        kind_q;
  logic              link_q;
  logic [AW-1:0]     addr_q;
  logic [CMD_MAX-1:0] cmd_q;
  logic [BYTE_W-1:0] byte_q;
  logic [CRC_W-1:0]  rcrc_q;
  logic              tx_valid_q;
  logic              tx_ack_q;
  logic [TXL_W-1:0]  tx_len_q;
  logic [TX_W-1:0]   tx_bits_q;
  logic              adv_q;

  // decoded frame
  logic               dec_read;
  logic               dec_write;
  logic [CMD_MAX-1:0] dec_cmd;
  logic [AW-1:0]      dec_addr;
  logic [BYTE_W-1:0]  dec_byte;
  logic [CRC_W-1:0]   dec_crc;

  // named events used by the checker
  logic frame_ok;
  logic wr_commit;
  logic cfg_bad;

  logic [LEN_W-1:0]  cmd_w;
  logic [LEN_W-1:0]  crc_nbits;
  logic              crc_start;
  logic [PAY_W-1:0]  crc_pay;
  logic              crc_done;
  logic [CRC_W-1:0]  crc_val;

  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;

  tagcmd_decode #(
    .RX_W (RX_W),
    .LEN_W(LEN_W),
    .AW   (AW)
  ) decode_i (
    .kind_i    (kind_q),
    .len_i     (rx_len_i),
    .bits_i    (rx_bits_i),
    .is_read_o (dec_read),
    .is_write_o(dec_write),
    .cmd_o     (dec_cmd),
    .addr_o    (dec_addr),
    .byte_o    (dec_byte),
    .crc_o     (dec_crc)
  );

  assign cmd_w     = LEN_W'(kind_cmd_w(kind_q));
  assign crc_nbits = cmd_w + LEN_W'(BYTE_W);
  assign frame_ok  = rx_valid_i && !rx_err_i;
  assign cfg_bad   = !kind_ok(kind_q);

  assign crc_start = (state_q == ST_RD_LOAD) ||
                     (state_q == ST_LINKED && frame_ok && dec_write);
  assign crc_pay   = (state_q == ST_RD_LOAD)
                   ? crc_payload(cmd_q, mem_rdata, int'(cmd_w))
                   : crc_payload(CMD_MAX'({dec_addr, 1'b0}), dec_byte, int'(cmd_w));

  tagcmd_crc4_serial #(
    .CNT_W(LEN_W)
  ) crc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (crc_start),
    .payload_i(crc_pay),
    .nbits_i  (crc_nbits),
    .done_o   (crc_done),
    .crc_o    (crc_val)
  );

  assign wr_commit = (state_q == ST_WR_CRC) && crc_done && (crc_val == rcrc_q);

  assign mem_we    = pre_we_i || wr_commit;
  assign mem_addr  = pre_we_i ? pre_addr_i : addr_q;
  assign mem_wdata = pre_we_i ? pre_data_i : byte_q;

  tagcmd_mem #(
    .DEPTH(MEM_DEPTH)
  ) mem_i (
    .clk    (clk),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(mem_wdata),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q     <= card_kind_e'(card_type_i);
      state_q    <= kind_ok(card_kind_e'(card_type_i)) ? ST_WAIT_IV : ST_OFF;
      link_q     <= 1'b0;
      addr_q     <= '0;
      cmd_q      <= '0;
      byte_q     <= '0;
      rcrc_q     <= '0;
      tx_valid_q <= 1'b0;
      tx_ack_q   <= 1'b0;
      tx_len_q   <= '0;
      tx_bits_q  <= '0;
      adv_q      <= 1'b0;
    end else begin
      tx_valid_q <= 1'b0;
      tx_ack_q   <= 1'b0;
      adv_q      <= 1'b0;
      case (state_q)
        ST_OFF: ;
        ST_WAIT_IV: begin
          if (frame_ok && rx_len_i == LEN_W'(IV_LEN)) begin
            tx_valid_q <= 1'b1;
            tx_len_q   <= TXL_W'(HS_LEN);
            tx_bits_q  <= TX_W'(kind_reply(kind_q));
            state_q    <= ST_WAIT_ACK;
          end
        end
        ST_WAIT_ACK: begin
          if (rx_valid_i) begin
            if (frame_ok && rx_len_i == LEN_W'(HS_LEN) &&
                rx_bits_i[HS_LEN-1:0] == kind_ack(kind_q)) begin
              link_q  <= 1'b1;
              adv_q   <= 1'b1;
              state_q <= ST_LINKED;
            end else begin
              state_q <= ST_WAIT_IV;
            end
          end
        end
        ST_LINKED: begin
          if (rx_valid_i) begin
            if (frame_ok && dec_read) begin
              addr_q  <= dec_addr;
              cmd_q   <= dec_cmd;
              state_q <= ST_RD_FETCH;
            end else if (frame_ok && dec_write) begin
              addr_q  <= dec_addr;
              byte_q  <= dec_byte;
              rcrc_q  <= dec_crc;
              state_q <= ST_WR_CRC;
            end else begin
              link_q  <= 1'b0;
              state_q <= ST_WAIT_IV;
            end
          end
        end
        ST_RD_FETCH: state_q <= ST_RD_LOAD;
        ST_RD_LOAD: begin
          byte_q  <= mem_rdata;
          state_q <= ST_RD_CRC;
        end
        ST_RD_CRC: begin
          if (crc_done) begin
            tx_valid_q <= 1'b1;
            tx_len_q   <= TXL_W'(TX_W);
            tx_bits_q  <= {crc_val, byte_q};
            state_q    <= ST_LINKED;
          end
        end
        ST_WR_CRC: begin
          if (crc_done) begin
            if (crc_val == rcrc_q) begin
              tx_valid_q <= 1'b1;
              tx_ack_q   <= 1'b1;
              tx_len_q   <= TXL_W'(1);
              tx_bits_q  <= TX_W'(1);
              state_q    <= ST_LINKED;
            end else begin
              link_q  <= 1'b0;
              state_q <= ST_WAIT_IV;
            end
          end
        end
        default: state_q <= ST_WAIT_IV;
      endcase
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_ack_o   = tx_ack_q;
  assign tx_len_o   = tx_len_q;
  assign tx_bits_o  = tx_bits_q;
  assign ref_adv_o  = adv_q;
  assign link_o     = link_q;

endmodule

// File: rtl/tagcmd_handler_chk.sv
module tagcmd_handler_chk
  import tagcmd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             link_o,
  input logic             tx_valid_o,
  input logic             tx_ack_o,
  input logic [TXL_W-1:0] tx_len_o,
  input logic             ref_adv_o,
  input logic             wr_commit,
  input logic             cfg_bad
);

  a_r10_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!link_o && !tx_valid_o && !ref_adv_o));

  a_r9_tx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |=> !tx_valid_o);

  a_r1_unsupported_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bad |-> (!link_o && !tx_valid_o));

  a_r3_adv_on_link_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ref_adv_o |-> $rose(link_o));

  a_r3_link_rise_has_adv: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_o) |-> ref_adv_o);

  a_r2_unlinked_reply_len: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !link_o) |-> (tx_len_o == TXL_W'(HS_LEN)));

  a_r5_read_reply_len: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && link_o && !tx_ack_o) |-> (tx_len_o == TXL_W'(TX_W)));

  a_r6_ack_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ack_o) |-> ($past(wr_commit) && tx_len_o == TXL_W'(1)));

  a_r7_store_only_linked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> link_o);

endmodule

bind tagcmd_handler tagcmd_handler_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_o    (link_o),
  .tx_valid_o(tx_valid_o),
  .tx_ack_o  (tx_ack_o),
  .tx_len_o  (tx_len_o),
  .ref_adv_o (ref_adv_o),
  .wr_commit (wr_commit),
  .cfg_bad   (cfg_bad)
);

// File: tb/tagcmd_handler_tb_top.sv
module tagcmd_handler_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  card_type = 2'd0;
  logic        rx_valid = 1'b0;
  logic        rx_err = 1'b0;
  logic [4:0]  rx_len = '0;
  logic [22:0] rx_bits = '0;
  logic        pre_we = 1'b0;
  logic [9:0]  pre_addr = '0;
  logic [7:0]  pre_data = '0;
  logic        tx_valid_o;
  logic        tx_ack_o;
  logic [3:0]  tx_len_o;
  logic [11:0] tx_bits_o;
  logic        ref_adv_o;
  logic        link_o;

  int n_checks = 0;
  int n_fail   = 0;
  int tx_seen  = 0;
  int exp_tx   = 0;
  int adv_seen = 0;
  int          last_len;
  logic [11:0] last_bits;
  logic        last_ack;
  logic [7:0]  exp_mem [1024];

  always #2 clk = ~clk;

  tagcmd_handler dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .card_type_i(card_type),
    .rx_valid_i (rx_valid),
    .rx_err_i   (rx_err),
    .rx_len_i   (rx_len),
    .rx_bits_i  (rx_bits),
    .pre_we_i   (pre_we),
    .pre_addr_i (pre_addr),
    .pre_data_i (pre_data),
    .tx_valid_o (tx_valid_o),
    .tx_ack_o   (tx_ack_o),
    .tx_len_o   (tx_len_o),
    .tx_bits_o  (tx_bits_o),
    .ref_adv_o  (ref_adv_o),
    .link_o     (link_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid_o) begin
        tx_seen   = tx_seen + 1;
        last_len  = int'(tx_len_o);
        last_bits = tx_bits_o;
        last_ack  = tx_ack_o;
      end
      if (ref_adv_o) adv_seen = adv_seen + 1;
    end
  end

  function automatic int cw_of(input int k);
    return (k == 0) ? 6 : (k == 1) ? 9 : 11;
  endfunction
  function automatic int size_of(input int k);
    return (k == 0) ? 22 : (k == 1) ? 256 : 1024;
  endfunction
  function automatic int reply_of(input int k);
    return (k == 0) ? 'h0D : (k == 1) ? 'h1D : 'h3D;
  endfunction
  function automatic int ack_of(input int k);
    return (k == 0) ? 'h19 : 'h39;
  endfunction

  function automatic logic [3:0] ref_crc(input int unsigned pay, input int n);
    logic [3:0] c;
    logic       fb;
    c = 4'h5;
    for (int i = 0; i < n; i++) begin
      fb = c[0] ^ pay[i];
      c  = {1'b0, c[3:1]};
      if (fb) c = c ^ 4'hC;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int len, input int unsigned bits, input bit err,
                      input int n_wait, output bit got);
    int base;
    base = tx_seen;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_err   = err;
    rx_len   = 5'(len);
    rx_bits  = 23'(bits);
    @(negedge clk);
    rx_valid = 1'b0;
    rx_err   = 1'b0;
    got = 1'b0;
    for (int i = 0; i < n_wait; i++) begin
      @(posedge clk);
      if (tx_seen != base) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic do_reset(input int k);
    @(negedge clk);
    rst_n     = 1'b0;
    card_type = 2'(k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 link after reset", link_o, 0);
    chk("R10 tx_valid after reset", tx_valid_o, 0);
    chk("R10 ref_adv after reset", ref_adv_o, 0);
  endtask

  task automatic link_up(input int k);
    bit got;
    int adv0;
    xfer(7, 'h2B, 1'b0, 20, got);
    exp_tx++;
    chk("R2 kind reply seen", got, 1);
    chk("R2 kind reply length", last_len, 6);
    chk("R2 kind reply code", last_bits[5:0], reply_of(k));
    adv0 = adv_seen;
    xfer(6, ack_of(k), 1'b0, 3, got);
    chk("R3 no reply to acknowledge", got, 0);
    chk("R3 link raised", link_o, 1);
    chk("R3 one timing advance", adv_seen - adv0, 1);
  endtask

  task automatic do_read(input int k, input int a, input string tag);
    bit          got;
    int          cw;
    int unsigned cmd;
    logic [3:0]  c;
    cw  = cw_of(k);
    cmd = (a << 1) | 1;
    xfer(cw, cmd, 1'b0, 60, got);
    exp_tx++;
    c = ref_crc((int'(exp_mem[a]) << cw) | cmd, cw + 8);
    chk({tag, " R5 read reply length"}, got ? last_len : 99, 12);
    chk({tag, " R4 R5 read reply bits"}, got ? last_bits : 'hFFFF, {c, exp_mem[a]});
  endtask

  task automatic do_write(input int k, input int a, input int v, input bit bad,
                          output bit got);
    int          cw;
    int unsigned cmd;
    logic [3:0]  c;
    cw  = cw_of(k);
    cmd = a << 1;
    c   = ref_crc((v << cw) | cmd, cw + 8);
    if (bad) c = c ^ 4'h1;
    xfer(cw + 12, (int'(c) << (cw + 8)) | (v << cw) | cmd, 1'b0, 60, got);
  endtask

  task automatic run_kind(input int k);
    bit got;
    int cw;
    int sz;
    int a;
    int v;
    cw = cw_of(k);
    sz = size_of(k);
    do_reset(k);
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      pre_we   = 1'b1;
      pre_addr = 10'(i);
      pre_data = 8'(i * 53 + k * 7 + 9);
      exp_mem[i] = 8'(i * 53 + k * 7 + 9);
    end
    @(negedge clk);
    pre_we = 1'b0;

    xfer(8, 'h2B, 1'b0, 20, got);
    chk("R2 wrong start length ignored", got, 0);
    xfer(7, 'h2B, 1'b1, 20, got);
    chk("R2 start frame with error ignored", got, 0);
    xfer(7, 'h11, 1'b0, 20, got);
    exp_tx++;
    chk("R2 kind reply length", got ? last_len : 99, 6);
    chk("R1 R2 kind reply code", last_bits[5:0], reply_of(k));
    xfer(6, ack_of(k) ^ 'h04, 1'b0, 20, got);
    chk("R3 wrong acknowledge no reply", got, 0);
    chk("R3 wrong acknowledge no link", link_o, 0);
    link_up(k);

    for (int i = 0; i < sz; i++) do_read(k, i, "R11 sweep");

    for (int i = 0; i < 16; i++) begin
      a = (i * 13 + k) % sz;
      v = (i * 29 + 3) & 'hFF;
      do_write(k, a, v, 1'b0, got);
      exp_tx++;
      chk("R6 write acknowledge seen", got, 1);
      chk("R6 acknowledge shape", {last_ack, last_len[3:0], last_bits}, {1'b1, 4'd1, 12'd1});
      exp_mem[a] = 8'(v);
      do_read(k, a, "R6 readback");
    end

    do_write(k, 3, 'hA5, 1'b1, got);
    chk("R7 bad checksum no reply", got, 0);
    chk("R7 bad checksum drops link", link_o, 0);
    link_up(k);
    do_read(k, 3, "R7 unchanged");

    xfer(cw + 1, 'h5, 1'b0, 30, got);
    chk("R8 odd length no reply", got, 0);
    chk("R8 odd length drops link", link_o, 0);
    link_up(k);
    xfer(cw, 'h3, 1'b1, 30, got);
    chk("R8 errored frame no reply", got, 0);
    chk("R8 errored frame drops link", link_o, 0);
    xfer(cw, 'h3, 1'b0, 30, got);
    chk("R8 read length while unlinked ignored", got, 0);
    link_up(k);
    do_read(k, sz - 1, "R1 top address");
  endtask

  initial begin : main
    bit got;
    for (int k = 0; k < 3; k++) run_kind(k);
    do_reset(3);
    xfer(7, 'h2B, 1'b0, 20, got);
    chk("R1 unsupported kind no reply", got, 0);
    xfer(6, 'h39, 1'b0, 20, got);
    chk("R1 unsupported kind no link", link_o, 0);
    repeat (4) @(negedge clk);
    chk("R9 reply count", tx_seen, exp_tx);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule